// File: doc/BRIEF.md
# SPI Serial Flash Command Front End

This block is the slave-side serial interface of a NOR flash. It runs on a system clock that is fast relative to the serial clock. SCK, chip select, SI and the hold input are oversampled and edge-detected. Bits are taken in on rising SCK edges and driven out on falling SCK edges, most significant bit first. The first byte of each frame is an opcode. Depending on that opcode, the block gathers a 24-bit address (the upper bits beyond the array width are dropped), skips don't-care bytes and then streams bytes back: array data, the live status byte, or the two identification codes.

The array is reached through a read port. The front end drives an address, and the returned byte must be valid within one system clock. Write-type opcodes are not executed here. When chip select rises, the opcode and address are presented to a neighbouring block as a one-cycle command. Any data bytes that follow the header are strobed out as they arrive. The block also handles the power-down state itself, and it handles a hold input that freezes the serial transfer.

Top module: `spi_flash_front`

## Requirements
- R1: Each SI bit is sampled on a rising SCK edge and each SO bit changes after a falling SCK edge, most significant bit first. When chip select falls, `mode3` captures the SCK level (1 = idle high).
- R2: Opcode 03h followed by three address bytes (most significant first) returns array bytes from that address, then from each following address, starting on the next falling edge.
- R3: Opcode 0Bh takes the same three address bytes plus one don't-care byte before array data is returned.
- R4: The read address increments after every byte, and it wraps from the top address (all ones in ADDR_W bits) to zero without a gap.
- R5: Opcode 05h returns the `status_in` byte, bit 7 first, and repeats it for as long as SCK runs.
- R6: Opcode 9Fh returns MFR_CODE (default 62h), then DEV_CODE (default 26h), and keeps alternating between them.
- R7: Opcode ABh takes two don't-care bytes and one address byte. Bit 0 of that byte set to 1 starts the output with DEV_CODE, and set to 0 starts it with MFR_CODE; the output then alternates. Receiving the ABh opcode byte clears power-down.
- R8: Opcode B9h, closed exactly at a byte boundary, sets `pwr_down`, unless `status_in` bit 0 (busy) is 1. While `pwr_down` is 1, every opcode except ABh is ignored: no command, no write strobe, no output.
- R9: Taking `hold_n` low while SCK is low freezes the transfer and floats SO. SCK edges during hold are ignored. Releasing `hold_n` resumes at the same bit. A chip-select rise clears the hold.
- R10: `so_oe` is 1 only while chip select is low and a read, status or ID byte is being shifted out. It is 0 after reset and during every header byte.
- R11: Opcodes 06h, 04h, C7h (one byte), 20h, D7h, D8h (four bytes), 01h (at least two bytes) and 02h (at least five bytes) produce one `cmd_valid` pulse, with `cmd_op` and `cmd_addr`. This happens only if chip select rises after a whole number of bytes.
- R12: An unrecognised opcode causes the rest of the frame to be ignored until chip select rises.
- R13: Each byte after the header of 02h (from the fifth byte) or 01h (from the second byte) is given on `wr_byte` with a one-cycle `wr_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |
| mode3 | output | 1 | SCK level captured when chip select fell |
| mem_addr | output | ADDR_W | Array read address |
| mem_data | input | 8 | Array read data |
| status_in | input | 8 | Status byte; bit 0 is busy |
| wr_valid | output | 1 | Write data byte strobe |
| wr_byte | output | 8 | Write data byte |
| cmd_valid | output | 1 | Command strobe at chip-select rise |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| pwr_down | output | 1 | Power-down state |

## Verification
The bench uses the default parameters: a 20-bit address and ID codes 62h and 26h. With a 20-bit address, the top of the array (FFFFFh) can be reached by one short read. A read from FFFFEh therefore exercises the wrap in four bytes. The mixed default codes make it visible which one comes first, and whether the output alternates or repeats. The serial clock runs at one eighth of the system clock, which leaves the one-cycle read port the margin it needs.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int          ADDR_W   = 20,
  parameter logic [7:0]  MFR_CODE = 8'h62,
  parameter logic [7:0]  DEV_CODE = 8'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              mode3,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  input  logic [7:0]        status_in,
  output logic              wr_valid,
  output logic [7:0]        wr_byte,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              pwr_down
);
  localparam logic [7:0] OP_READ = 8'h03, OP_FAST = 8'h0B, OP_STAT = 8'h05;
  localparam logic [7:0] OP_ID1  = 8'h9F, OP_ID2  = 8'hAB, OP_PDN  = 8'hB9;
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_CERS = 8'hC7;
  localparam logic [7:0] OP_SER1 = 8'h20, OP_SER2 = 8'hD7, OP_BERS = 8'hD8;
  localparam logic [7:0] OP_PROG = 8'h02, OP_SRWR = 8'h01;

  logic              cs_q, sck_q, held, ign, out_on, drv, id_sel, so_r;
  logic [2:0]        bit_cnt, byte_cnt;
  logic [7:0]        rx, tx, op;
  logic [ADDR_W-1:0] addr, rd_ptr;

  function automatic logic [2:0] need_bytes(input logic [7:0] o);
    if (o == OP_WREN || o == OP_WRDI || o == OP_CERS) return 3'd1;
    if (o == OP_SER1 || o == OP_SER2 || o == OP_BERS) return 3'd4;
    if (o == OP_SRWR) return 3'd2;
    if (o == OP_PROG) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic known(input logic [7:0] o);
    return need_bytes(o) != 3'd0 || o == OP_READ || o == OP_FAST || o == OP_STAT ||
           o == OP_ID1 || o == OP_ID2 || o == OP_PDN;
  endfunction

  wire              active    = ~cs_n & ~held;
  wire              sck_rise  = active & sck & ~sck_q;
  wire              sck_fall  = active & ~sck & sck_q;
  wire              cs_rise   = cs_n & ~cs_q;
  wire [7:0]        byte_in   = {rx[6:0], si};
  wire [ADDR_W-1:0] addr_nx   = {addr[ADDR_W-9:0], byte_in};
  wire              is_id     = (op == OP_ID1) || (op == OP_ID2);
  wire [7:0]        next_byte = (op == OP_STAT) ? status_in :
                                is_id ? (id_sel ? DEV_CODE : MFR_CODE) : mem_data;

  assign so       = so_r;
  assign so_oe    = drv & ~held & ~cs_n;
  assign mem_addr = rd_ptr;
  assign pwr_down = pwr_q;

  logic pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; sck_q <= 1'b0; held <= 1'b0; mode3 <= 1'b0; pwr_q <= 1'b0;
      ign <= 1'b0; out_on <= 1'b0; drv <= 1'b0; id_sel <= 1'b0; so_r <= 1'b0;
      bit_cnt <= '0; byte_cnt <= '0; rx <= '0; tx <= '0; op <= '0;
      addr <= '0; rd_ptr <= '0;
      wr_valid <= 1'b0; wr_byte <= '0; cmd_valid <= 1'b0; cmd_op <= '0; cmd_addr <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      cs_q      <= cs_n;
      sck_q     <= sck;

      if (cs_n)      held <= 1'b0;
      else if (held) held <= ~hold_n;
      else           held <= ~hold_n & ~sck;

      if (~cs_n && cs_q) mode3 <= sck;

      if (cs_rise && !ign && bit_cnt == 3'd0 && byte_cnt != 3'd0) begin
        if (op == OP_PDN) begin
          if (!status_in[0]) pwr_q <= 1'b1;
        end else if (need_bytes(op) != 3'd0 && byte_cnt >= need_bytes(op)) begin
          cmd_valid <= 1'b1;
          cmd_op    <= op;
          cmd_addr  <= addr;
        end
      end

      if (cs_n) begin
        bit_cnt <= '0; byte_cnt <= '0; ign <= 1'b0; out_on <= 1'b0; drv <= 1'b0;
      end

      if (sck_rise) begin
        rx      <= byte_in;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
          if (!ign) begin
            if (byte_cnt == 3'd0) begin
              op <= byte_in;
              if (pwr_q && byte_in != OP_ID2) ign <= 1'b1;
              else if (!known(byte_in)) ign <= 1'b1;
              if (byte_in == OP_ID2) pwr_q <= 1'b0;
              if (!pwr_q && (byte_in == OP_STAT || byte_in == OP_ID1)) begin
                out_on <= 1'b1;
                id_sel <= 1'b0;
              end
            end else begin
              if (byte_cnt <= 3'd3) addr <= addr_nx;
              if (op == OP_READ && byte_cnt == 3'd3) begin
                rd_ptr <= addr_nx;
                out_on <= 1'b1;
              end
              if (op == OP_FAST && byte_cnt == 3'd3) rd_ptr <= addr_nx;
              if (op == OP_FAST && byte_cnt == 3'd4) out_on <= 1'b1;
              if (op == OP_ID2 && byte_cnt == 3'd3) begin
                id_sel <= byte_in[0];
                out_on <= 1'b1;
              end
              if ((op == OP_PROG && byte_cnt >= 3'd4) || op == OP_SRWR) begin
                wr_valid <= 1'b1;
                wr_byte  <= byte_in;
              end
            end
          end
        end
      end

      if (sck_fall && out_on) begin
        if (bit_cnt == 3'd0) begin
          so_r   <= next_byte[7];
          tx     <= {next_byte[6:0], 1'b0};
          drv    <= 1'b1;
          id_sel <= ~id_sel;
          if (op == OP_READ || op == OP_FAST) rd_ptr <= rd_ptr + 1'b1;
        end else begin
          so_r <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so,
  input logic so_oe,
  input logic cmd_valid,
  input logic wr_valid,
  input logic pwr_down
);
  a_r1_so_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(so_oe) && so_oe && so != $past(so)) |-> !$past(sck));

  a_r8_no_cmd_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(pwr_down));

  a_r9_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !sck && !cs_n) |=> !so_oe);

  a_r10_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !$past(cs_n));

  a_r11_cmd_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

  a_r13_wr_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(sck));
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so(so), .so_oe(so_oe), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
  .pwr_down(pwr_down)
);

// File: tb/test_spi_flash_front.sv
module test_spi_flash_front;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status_in = 8'h00;
  logic so, so_oe, mode3, wr_valid, cmd_valid, pwr_down;
  logic [AW-1:0] mem_addr, cmd_addr;
  logic [7:0] mem_data, wr_byte, cmd_op;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction
  assign mem_data = memf(mem_addr);

  spi_flash_front i_spi_flash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mode3(mode3), .mem_addr(mem_addr), .mem_data(mem_data),
    .status_in(status_in), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .pwr_down(pwr_down)
  );

  int n_chk = 0, n_fail = 0, n_cmd = 0, mbits = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] wr_log[$];
  logic [7:0] mbyte = 8'h00, last_op = 8'h00;
  logic [AW-1:0] last_addr = '0;
  logic psck = 1'b0, oe_seen = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cs_n) mbits = 0;
    else if (sck && !psck && so_oe) begin
      mbyte = {mbyte[6:0], so};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", mbyte, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mbyte == e, t, mbyte, e);
        end
      end
    end
    if (so_oe) oe_seen = 1'b1;
    if (cmd_valid) begin n_cmd++; last_op = cmd_op; last_addr = cmd_addr; end
    if (wr_valid) wr_log.push_back(wr_byte);
    psck = sck;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck <= 1'b0; si <= b[i]; tick(4);
      sck <= 1'b1; tick(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic start(input logic m3);
    sck <= m3; tick(2);
    cs_n <= 1'b0; oe_seen = 1'b0; tick(4);
  endtask

  task automatic stop();
    tick(4); cs_n <= 1'b1; tick(4);
    sck <= 1'b0; tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    tick(3); rst_n <= 1'b1; tick(3);
    check(so_oe == 1'b0, "R10 reset so_oe", so_oe, 0);
    check(pwr_down == 1'b0, "R8 reset pwr_down", pwr_down, 0);
    check(cmd_valid == 1'b0, "R11 reset cmd_valid", cmd_valid, 0);

    // R2 R1: plain read, mode 0
    start(1'b0);
    check(mode3 == 1'b0, "R1 mode0 detect", mode3, 0);
    send_byte(8'h03); send_byte(8'h01); send_byte(8'h23); send_byte(8'h45);
    for (int k = 0; k < 3; k++) expect_byte(memf(20'h12345 + k), "R2 read data");
    for (int k = 0; k < 3; k++) send_byte(8'h00);
    stop();

    // R3 R1: fast read, mode 3
    start(1'b1);
    check(mode3 == 1'b1, "R1 mode3 detect", mode3, 1);
    send_byte(8'h0B); send_byte(8'h00); send_byte(8'hAB); send_byte(8'hCD);
    send_byte(8'hFF);
    for (int k = 0; k < 2; k++) expect_byte(memf(20'h0ABCD + k), "R3 fast read data");
    for (int k = 0; k < 2; k++) send_byte(8'h00);
    stop();

    // R4: wrap at top
    start(1'b0);
    send_byte(8'h03); send_byte(8'h0F); send_byte(8'hFF); send_byte(8'hFE);
    expect_byte(memf(20'hFFFFE), "R4 wrap"); expect_byte(memf(20'hFFFFF), "R4 wrap");
    expect_byte(memf(20'h00000), "R4 wrap"); expect_byte(memf(20'h00001), "R4 wrap");
    for (int k = 0; k < 4; k++) send_byte(8'h00);
    stop();

    // R5: status repeats
    status_in = 8'hA4;
    start(1'b0);
    send_byte(8'h05);
    check(oe_seen == 1'b0, "R10 no output during header", oe_seen, 0);
    expect_byte(8'hA4, "R5 status"); expect_byte(8'hA4, "R5 status repeat");
    send_byte(8'h00); send_byte(8'h00);
    stop();
    status_in = 8'h00;

    // R6: 9F alternates
    start(1'b0);
    send_byte(8'h9F);
    expect_byte(8'h62, "R6 id1"); expect_byte(8'h26, "R6 id1"); expect_byte(8'h62, "R6 id1");
    for (int k = 0; k < 3; k++) send_byte(8'h00);
    stop();

    // R7: AB with bit0 = 1
    start(1'b0);
    send_byte(8'hAB); send_byte(8'h00); send_byte(8'h00); send_byte(8'h01);
    expect_byte(8'h26, "R7 id2 dev first"); expect_byte(8'h62, "R7 id2 alternate");
    send_byte(8'h00); send_byte(8'h00);
    stop();

    // R11: single-byte command and erase with address
    c0 = n_cmd;
    start(1'b0); send_byte(8'h06); stop();
    check(n_cmd == c0 + 1, "R11 wren count", n_cmd, c0 + 1);
    check(last_op == 8'h06, "R11 wren op", last_op, 8'h06);
    start(1'b1);
    send_byte(8'hD8); send_byte(8'h03); send_byte(8'h00); send_byte(8'h00);
    stop();
    check(last_op == 8'hD8, "R11 erase op", last_op, 8'hD8);
    check(last_addr == 20'h30000, "R11 erase addr", last_addr, 20'h30000);
    c0 = n_cmd;
    start(1'b0); send_byte(8'h06); send_bits(8'h00, 3); stop();
    check(n_cmd == c0, "R11 misaligned rejected", n_cmd, c0);
    start(1'b0); send_byte(8'h20); send_byte(8'h00); stop();
    check(n_cmd == c0, "R11 short header rejected", n_cmd, c0);

    // R13: program data strobes
    wr_log.delete();
    start(1'b0);
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h12); send_byte(8'h34);
    send_byte(8'h5E); send_byte(8'hC1);
    stop();
    check(wr_log.size() == 2, "R13 strobe count", wr_log.size(), 2);
    if (wr_log.size() == 2) begin
      check(wr_log[0] == 8'h5E, "R13 first byte", wr_log[0], 8'h5E);
      check(wr_log[1] == 8'hC1, "R13 second byte", wr_log[1], 8'hC1);
    end
    check(last_op == 8'h02 && last_addr == 20'h01234, "R11 program cmd", last_addr, 20'h01234);

    // R12: unknown opcode swallows frame
    c0 = n_cmd;
    start(1'b0); send_byte(8'h5A); send_byte(8'h05); send_byte(8'h00); stop();
    check(oe_seen == 1'b0, "R12 no output", oe_seen, 0);
    check(n_cmd == c0, "R12 no command", n_cmd, c0);

    // R8: power-down
    status_in = 8'h01;
    start(1'b0); send_byte(8'hB9); stop();
    check(pwr_down == 1'b0, "R8 busy ignores B9", pwr_down, 0);
    status_in = 8'h00;
    start(1'b0); send_byte(8'hB9); stop();
    check(pwr_down == 1'b1, "R8 enter", pwr_down, 1);
    c0 = n_cmd;
    start(1'b0); send_byte(8'h06); stop();
    check(n_cmd == c0, "R8 cmd ignored in pd", n_cmd, c0);
    start(1'b0); send_byte(8'h9F); send_byte(8'h00); stop();
    check(oe_seen == 1'b0, "R8 id1 ignored in pd", oe_seen, 0);
    start(1'b0);
    send_byte(8'hAB);
    check(pwr_down == 1'b0, "R7 AB exits pd", pwr_down, 0);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    expect_byte(8'h62, "R7 id2 mfr first"); expect_byte(8'h26, "R7 id2 alternate");
    send_byte(8'h00); send_byte(8'h00);
    stop();

    // R9: hold mid-read
    start(1'b0);
    send_byte(8'h03); send_byte(8'h00); send_byte(8'h01); send_byte(8'h00);
    expect_byte(memf(20'h00100), "R9 before hold"); expect_byte(memf(20'h00101), "R9 after hold");
    send_byte(8'h00);
    sck <= 1'b0; tick(4);
    hold_n <= 1'b0; tick(3);
    check(so_oe == 1'b0, "R9 SO floats in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin sck <= 1'b1; tick(4); sck <= 1'b0; tick(4); end
    hold_n <= 1'b1; tick(3);
    check(so_oe == 1'b1, "R9 resume drive", so_oe, 1);
    send_byte(8'h00);
    stop();

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule